// File: doc/BRIEF.md
# Paged Harvard-Bus Memory Decoder

This block sits between an 8-bit controller core and the on-chip memories. The core has separate code and data address spaces, and only the active strobe tells them apart. The block decodes the 16-bit bus address together with a fetch strobe, a data read strobe and a data write strobe. It produces a chip select and a local address for each of three memories: a 256 KB main flash, a 32 KB boot flash and a 32 KB SRAM.

In code space, the lower half of the address range is a common window whose contents do not depend on the page. The upper half is a 32 KB window into main flash, and a software-written page value chooses which segment it shows. A routing value, also written by software, can make several changes:

- It can move the common code window from boot flash to a fixed main-flash segment.
- It can send upper-window fetches to SRAM, so that code runs from RAM.
- It can open the upper data window onto main flash, so that code running from boot flash can write the main array.

Both values are held in two registers. Software writes them with a data-space write to two fixed addresses, and those accesses reach no memory.

Top module: `hvbus_decoder`

## Requirements
- R1: After reset the page is 0 and the routing value is 0. A fetch at 0x0000 then selects boot flash at local address 0, and a fetch at 0x8000 selects main flash at local address 0.
- R2: With routing bit 0 clear, a fetch with address bit 15 low selects boot flash. Its local address is address bits 14:0.
- R3: With routing bit 0 set, a fetch with address bit 15 low selects main flash. Its local address is {3'd0, address[14:0]}, whatever the page holds.
- R4: With routing bit 2 clear, a fetch with address bit 15 high selects main flash. Its local address is {page, address[14:0]}.
- R5: With routing bit 2 set, a fetch with address bit 15 high selects SRAM at address bits 14:0. Lower-half fetches are not affected.
- R6: With routing bit 1 clear, a data read or write to any address other than the two register addresses selects SRAM at address bits 14:0.
- R7: With routing bit 1 set, a data access with address bit 15 high selects main flash at {page, address[14:0]}. Lower-half data accesses still select SRAM.
- R8: A data write to 0x7FF0 loads bits 2:0 of the write data into the page. A data write to 0x7FF1 loads bits 2:0 into the routing value. Both take effect from the next clock cycle.
- R9: Data reads and writes at 0x7FF0 or 0x7FF1 assert no chip select. No other access changes the page or the routing value.
- R10: At most one chip select is asserted at any time, and none is asserted while all three strobes are low.
- R11: When the fetch strobe is high, the access is decoded as a code fetch, even if a data strobe is high at the same time. Such an access writes no register.
- R12: The memory write enable is high only during a data write that selects main flash or SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page and routing registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Core address bus |
| fetch | input | 1 | Code fetch strobe, active high |
| dread | input | 1 | Data read strobe, active high |
| dwrite | input | 1 | Data write strobe, active high |
| wdata | input | 8 | Data bus during writes |
| main_cs | output | 1 | Main flash select |
| main_addr | output | 18 | Main flash local address |
| boot_cs | output | 1 | Boot flash select |
| boot_addr | output | 15 | Boot flash local address |
| ram_cs | output | 1 | SRAM select |
| ram_addr | output | 15 | SRAM local address |
| mem_we | output | 1 | Write enable to the selected memory |

## Verification
The bench builds the block with its default parameters: a 3-bit page, a 15-bit window and RAM execution enabled. This makes every pair of page value and routing value reachable.

For each of the 64 pairs, the bench sweeps an address lattice across both halves of the space, including the window edges. It combines each address with every strobe pattern, including a fetch that overlaps a data write. The expected select and local address come from the arithmetic of the window rules.

Separate sequences cover the reset values, the register hits and the cases where a register must stay unchanged.

// File: rtl/hvd_pkg.sv
`timescale 1ns/1ps
package hvd_pkg;
   localparam int ROUTE_W = 3;

   // routing value: bit0 code_main, bit1 data_main, bit2 code_ram
   typedef struct packed {
      logic code_ram;
      logic data_main;
      logic code_main;
   } route_t;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_MAIN = 2'd1,
      TGT_BOOT = 2'd2,
      TGT_RAM  = 2'd3
   } tgt_e;
endpackage

// File: rtl/hvd_regs.sv
`timescale 1ns/1ps
module hvd_regs #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 3,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] PAGE_REG_ADDR  = 16'h7FF0,
   parameter logic [ADDR_W-1:0] ROUTE_REG_ADDR = 16'h7FF1,
   parameter bit RAM_EXEC_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                fetch,
   input  logic                dwrite,
   input  logic [DATA_W-1:0]   wdata,
   output logic [PAGE_W-1:0]   page_q,
   output hvd_pkg::route_t     route_q
);
   logic wr_ok;
   logic hit_page;
   logic hit_route;

   assign wr_ok     = dwrite & ~fetch;
   assign hit_page  = wr_ok & (addr == PAGE_REG_ADDR);
   assign hit_route = wr_ok & (addr == ROUTE_REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (hit_page) begin
         page_q <= wdata[PAGE_W-1:0];
      end
   end

   logic code_main_q;
   logic data_main_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_main_q <= 1'b0;
         data_main_q <= 1'b0;
      end else if (hit_route) begin
         code_main_q <= wdata[0];
         data_main_q <= wdata[1];
      end
   end

   generate
      if (RAM_EXEC_EN) begin : g_ram_exec
         logic code_ram_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code_ram_q <= 1'b0;
            end else if (hit_route) begin
               code_ram_q <= wdata[2];
            end
         end
         assign route_q.code_ram = code_ram_q;
      end else begin : g_no_ram_exec
         assign route_q.code_ram = 1'b0;
      end
   endgenerate

   assign route_q.code_main = code_main_q;
   assign route_q.data_main = data_main_q;
endmodule

// File: rtl/hvd_code_dec.sv
`timescale 1ns/1ps
module hvd_code_dec #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_W     = 3,
   parameter int COMMON_SEG = 0,
   localparam int SEG_W     = ADDR_W - 1,
   localparam int MAIN_W    = PAGE_W + SEG_W
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [PAGE_W-1:0]  page,
   input  hvd_pkg::route_t    route,
   output hvd_pkg::tgt_e      tgt,
   output logic [MAIN_W-1:0]  local_addr
);
   import hvd_pkg::*;
   localparam logic [PAGE_W-1:0] COMMON_P = PAGE_W'(COMMON_SEG);

   always_comb begin
      tgt        = TGT_NONE;
      local_addr = '0;
      if (!addr[ADDR_W-1]) begin
         if (route.code_main) begin
            tgt        = TGT_MAIN;
            local_addr = {COMMON_P, addr[SEG_W-1:0]};
         end else begin
            tgt        = TGT_BOOT;
            local_addr = {{PAGE_W{1'b0}}, addr[SEG_W-1:0]};
         end
      end else if (route.code_ram) begin
         tgt        = TGT_RAM;
         local_addr = {{PAGE_W{1'b0}}, addr[SEG_W-1:0]};
      end else begin
         tgt        = TGT_MAIN;
         local_addr = {page, addr[SEG_W-1:0]};
      end
   end
endmodule

// File: rtl/hvd_data_dec.sv
`timescale 1ns/1ps
module hvd_data_dec #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 3,
   parameter logic [ADDR_W-1:0] PAGE_REG_ADDR  = 16'h7FF0,
   parameter logic [ADDR_W-1:0] ROUTE_REG_ADDR = 16'h7FF1,
   localparam int SEG_W  = ADDR_W - 1,
   localparam int MAIN_W = PAGE_W + SEG_W
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [PAGE_W-1:0]  page,
   input  hvd_pkg::route_t    route,
   output hvd_pkg::tgt_e      tgt,
   output logic [MAIN_W-1:0]  local_addr
);
   import hvd_pkg::*;
   logic reg_hit;

   assign reg_hit = (addr == PAGE_REG_ADDR) | (addr == ROUTE_REG_ADDR);

   always_comb begin
      tgt        = TGT_NONE;
      local_addr = '0;
      if (reg_hit) begin
         tgt = TGT_NONE;
      end else if (addr[ADDR_W-1] && route.data_main) begin
         tgt        = TGT_MAIN;
         local_addr = {page, addr[SEG_W-1:0]};
      end else begin
         tgt        = TGT_RAM;
         local_addr = {{PAGE_W{1'b0}}, addr[SEG_W-1:0]};
      end
   end
endmodule

// File: rtl/hvbus_decoder.sv
`timescale 1ns/1ps
module hvbus_decoder #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_W     = 3,
   parameter int DATA_W     = 8,
   parameter int COMMON_SEG = 0,
   parameter logic [ADDR_W-1:0] PAGE_REG_ADDR  = 16'h7FF0,
   parameter logic [ADDR_W-1:0] ROUTE_REG_ADDR = 16'h7FF1,
   parameter bit RAM_EXEC_EN = 1'b1,
   localparam int SEG_W  = ADDR_W - 1,
   localparam int MAIN_W = PAGE_W + SEG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              fetch,
   input  logic              dread,
   input  logic              dwrite,
   input  logic [DATA_W-1:0] wdata,
   output logic              main_cs,
   output logic [MAIN_W-1:0] main_addr,
   output logic              boot_cs,
   output logic [SEG_W-1:0]  boot_addr,
   output logic              ram_cs,
   output logic [SEG_W-1:0]  ram_addr,
   output logic              mem_we
);
   import hvd_pkg::*;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("hvbus_decoder: ADDR_W too small");
      end
      if (PAGE_W < 1 || PAGE_W > DATA_W) begin : g_bad_page
         $error("hvbus_decoder: PAGE_W must be 1..DATA_W");
      end
      if (DATA_W < ROUTE_W) begin : g_bad_data
         $error("hvbus_decoder: DATA_W narrower than routing value");
      end
      if (COMMON_SEG < 0 || COMMON_SEG >= (1 << PAGE_W)) begin : g_bad_common
         $error("hvbus_decoder: COMMON_SEG out of page range");
      end
      if (PAGE_REG_ADDR[ADDR_W-1] || ROUTE_REG_ADDR[ADDR_W-1]) begin : g_bad_reg_hi
         $error("hvbus_decoder: register addresses must lie in the lower half");
      end
      if (PAGE_REG_ADDR == ROUTE_REG_ADDR) begin : g_bad_reg_eq
         $error("hvbus_decoder: register addresses must differ");
      end
   endgenerate

   logic [PAGE_W-1:0] page_q;
   route_t            route_q;

   hvd_regs #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
      .PAGE_REG_ADDR(PAGE_REG_ADDR), .ROUTE_REG_ADDR(ROUTE_REG_ADDR),
      .RAM_EXEC_EN(RAM_EXEC_EN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .fetch(fetch),
      .dwrite(dwrite), .wdata(wdata), .page_q(page_q), .route_q(route_q)
   );

   tgt_e              code_tgt, data_tgt, tgt;
   logic [MAIN_W-1:0] code_loc, data_loc, loc;

   hvd_code_dec #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .COMMON_SEG(COMMON_SEG)
   ) u_code (
      .addr(bus_addr), .page(page_q), .route(route_q),
      .tgt(code_tgt), .local_addr(code_loc)
   );

   hvd_data_dec #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
      .PAGE_REG_ADDR(PAGE_REG_ADDR), .ROUTE_REG_ADDR(ROUTE_REG_ADDR)
   ) u_data (
      .addr(bus_addr), .page(page_q), .route(route_q),
      .tgt(data_tgt), .local_addr(data_loc)
   );

   always_comb begin
      if (fetch) begin
         tgt = code_tgt;
         loc = code_loc;
      end else if (dread || dwrite) begin
         tgt = data_tgt;
         loc = data_loc;
      end else begin
         tgt = TGT_NONE;
         loc = '0;
      end
   end

   assign main_cs   = (tgt == TGT_MAIN);
   assign boot_cs   = (tgt == TGT_BOOT);
   assign ram_cs    = (tgt == TGT_RAM);
   assign main_addr = loc;
   assign boot_addr = loc[SEG_W-1:0];
   assign ram_addr  = loc[SEG_W-1:0];
   assign mem_we    = dwrite & ~fetch & (tgt != TGT_NONE);
endmodule

// File: rtl/hvd_chk.sv
`timescale 1ns/1ps
module hvd_chk #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 3,
   parameter logic [ADDR_W-1:0] PAGE_REG_ADDR  = 16'h7FF0,
   parameter logic [ADDR_W-1:0] ROUTE_REG_ADDR = 16'h7FF1,
   localparam int MAIN_W = PAGE_W + ADDR_W - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              fetch,
   input logic              dread,
   input logic              dwrite,
   input logic              main_cs,
   input logic [MAIN_W-1:0] main_addr,
   input logic              boot_cs,
   input logic              ram_cs,
   input logic              mem_we,
   input logic [PAGE_W-1:0] page_q
);
   logic reg_addr;
   assign reg_addr = (bus_addr == PAGE_REG_ADDR) || (bus_addr == ROUTE_REG_ADDR);

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({main_cs, boot_cs, ram_cs}) <= 1); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch || dread || dwrite) |-> !(main_cs || boot_cs || ram_cs)); // R10
   AST_REG_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch && (dread || dwrite) && reg_addr) |-> !(main_cs || boot_cs || ram_cs)); // R9
   AST_BOOT_ONLY_LOW_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      boot_cs |-> (fetch && !bus_addr[ADDR_W-1])); // R2
   AST_WE_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (dwrite && !fetch && (main_cs || ram_cs))); // R12
   AST_UPPER_MAIN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (main_cs && bus_addr[ADDR_W-1]) |-> (main_addr[MAIN_W-1 -: PAGE_W] == page_q)); // R4
   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(dwrite && !fetch && bus_addr == PAGE_REG_ADDR) |=> $stable(page_q)); // R9
endmodule

bind hvbus_decoder hvd_chk #(
   .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
   .PAGE_REG_ADDR(PAGE_REG_ADDR), .ROUTE_REG_ADDR(ROUTE_REG_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .fetch(fetch),
   .dread(dread), .dwrite(dwrite), .main_cs(main_cs), .main_addr(main_addr),
   .boot_cs(boot_cs), .ram_cs(ram_cs), .mem_we(mem_we), .page_q(page_q)
);

// File: tb/sim_hvbus_decoder.sv
`timescale 1ns/1ps
module sim_hvbus_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        fetch = 1'b0, dread = 1'b0, dwrite = 1'b0;
   logic [7:0]  wdata = '0;
   logic        main_cs, boot_cs, ram_cs, mem_we;
   logic [17:0] main_addr;
   logic [14:0] boot_addr, ram_addr;

   int n_chk = 0;
   int n_err = 0;
   logic [2:0] m_page = 3'd0;
   logic [2:0] m_route = 3'd0;

   always #2.5 clk = ~clk;

   hvbus_decoder u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .fetch(fetch),
      .dread(dread), .dwrite(dwrite), .wdata(wdata),
      .main_cs(main_cs), .main_addr(main_addr), .boot_cs(boot_cs),
      .boot_addr(boot_addr), .ram_cs(ram_cs), .ram_addr(ram_addr),
      .mem_we(mem_we)
   );

   // expected select: 0 none, 1 main, 2 boot, 3 ram
   task automatic model(input logic [15:0] a, input logic f, r, w,
                        output int sel, output logic [17:0] loc, output string tag);
      sel = 0; loc = '0; tag = "R10";
      if (f) begin
         if (!a[15]) begin
            if (m_route[0]) begin sel = 1; loc = {3'd0, a[14:0]}; tag = "R3"; end
            else begin sel = 2; loc = {3'd0, a[14:0]}; tag = "R2"; end
         end else if (m_route[2]) begin
            sel = 3; loc = {3'd0, a[14:0]}; tag = "R5";
         end else begin
            sel = 1; loc = {m_page, a[14:0]}; tag = "R4";
         end
         if (r || w) tag = {tag, "/R11"};
      end else if (r || w) begin
         if (a == 16'h7FF0 || a == 16'h7FF1) begin sel = 0; tag = "R9"; end
         else if (a[15] && m_route[1]) begin sel = 1; loc = {m_page, a[14:0]}; tag = "R7"; end
         else begin sel = 3; loc = {3'd0, a[14:0]}; tag = "R6"; end
      end
   endtask

   task automatic probe(input logic [15:0] a, input logic f, r, w, input string extra);
      int sel, act_sel;
      logic [17:0] loc, act_loc;
      string tag;
      logic exp_we;
      bus_addr = a; fetch = f; dread = r; dwrite = w;
      #1;
      model(a, f, r, w, sel, loc, tag);
      act_sel = main_cs ? 1 : boot_cs ? 2 : ram_cs ? 3 : 0;
      if ((main_cs + boot_cs + ram_cs) > 1) act_sel = 9;
      act_loc = main_cs ? main_addr : boot_cs ? {3'd0, boot_addr} : ram_cs ? {3'd0, ram_addr} : 18'd0;
      n_chk++;
      if (act_sel != sel || act_loc != loc) begin
         n_err++;
         $display("FAIL %s%s addr=%h f%0d r%0d w%0d page=%0d route=%0d: sel=%0d loc=%h expected sel=%0d loc=%h",
                  tag, extra, a, f, r, w, m_page, m_route, act_sel, act_loc, sel, loc);
      end
      exp_we = w && !f && sel != 0;
      n_chk++;
      if (mem_we !== exp_we) begin
         n_err++;
         $display("FAIL R12 addr=%h f%0d w%0d: mem_we=%0b expected %0b", a, f, w, mem_we, exp_we);
      end
   endtask

   task automatic idle();
      bus_addr = '0; fetch = 0; dread = 0; dwrite = 0;
   endtask

   // R8: register write over one clock edge
   task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; wdata = d; dwrite = 1; fetch = 0; dread = 0;
      @(negedge clk);
      idle();
      if (a == 16'h7FF0) m_page = d[2:0];
      if (a == 16'h7FF1) m_route = d[2:0];
   endtask

   initial begin
      #900_000;
      n_err++;
      $display("FAIL watchdog R1..: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] pts[$];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      probe(16'h0000, 1, 0, 0, " R1 reset");
      probe(16'h8000, 1, 0, 0, " R1 reset");
      probe(16'h0000, 0, 0, 0, " R1 idle");

      // R8 page load, low bits only
      wr_reg(16'h7FF0, 8'hFD);
      probe(16'h8123, 1, 0, 0, " R8 page=5");
      probe(16'h7FF0, 0, 1, 0, " R9 read reg");
      // R9 read at register address must not change page
      @(negedge clk); bus_addr = 16'h7FF0; dread = 1; wdata = 8'h02;
      @(negedge clk); idle();
      probe(16'hFFFF, 1, 0, 0, " R9 page held after read");
      // R11 fetch with write at register: no register load
      @(negedge clk); bus_addr = 16'h7FF0; fetch = 1; dwrite = 1; wdata = 8'h07;
      @(negedge clk); idle();
      probe(16'h8001, 1, 0, 0, " R11 page held");
      // R9 write to ordinary address leaves page alone
      @(negedge clk); bus_addr = 16'h7FEF; dwrite = 1; wdata = 8'h01;
      @(negedge clk); idle();
      probe(16'h8001, 1, 0, 0, " R9 page held after ram write");
      // R8 route load
      wr_reg(16'h7FF1, 8'hF9);
      probe(16'h1234, 1, 0, 0, " R8 route=1");
      probe(16'h9234, 0, 0, 1, " R8 route=1");

      // near-exhaustive sweep
      for (int k = 0; k < 256; k++) pts.push_back(16'(k * 16'h0101 + (k % 7)));
      pts.push_back(16'h7FFF); pts.push_back(16'h8000);
      pts.push_back(16'hFFFF); pts.push_back(16'h0000);
      pts.push_back(16'h7FF0); pts.push_back(16'h7FF1);
      for (int rt = 0; rt < 8; rt++) begin
         wr_reg(16'h7FF1, 8'(rt));
         for (int pg = 0; pg < 8; pg++) begin
            wr_reg(16'h7FF0, 8'(pg));
            @(negedge clk);
            foreach (pts[i]) begin
               probe(pts[i], 0, 0, 0, "");
               probe(pts[i], 1, 0, 0, "");
               probe(pts[i], 0, 1, 0, "");
               probe(pts[i], 1, 0, 1, "");
               // write probes at register addresses would cross an edge; reads cover them
               if (pts[i] != 16'h7FF0 && pts[i] != 16'h7FF1) probe(pts[i], 0, 0, 1, "");
               idle();
            end
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end
endmodule